// File: doc/BRIEF.md
# Raster Timing Counter Generator

This block produces the raster timing of one display pipe, at one pixel per clock. Six programmable values describe the raster:

- the line length in pixels (`cfgHtotal`);
- the pixel positions where horizontal blanking and horizontal sync begin;
- the frame length in lines (`cfgVtotal`);
- the lines where vertical blanking begins and ends.

The block runs four counters from these values. A horizontal position and a true line index give the raster coordinate. Coordinate (0,0) is the first pixel of horizontal active on the first active line.

Two further counters copy the behaviour that timestamping software expects. The frame pixel counter is anchored at that same first active pixel. The scanline counter steps at the leading edge of horizontal sync rather than at line start, so before sync it lags the true line by one.

Two single-cycle event strobes are produced. The start-of-vblank event comes at sync start of the last active line. The frame-start event comes at blanking start of the following line. A level flag marks the vblank window, measured in the same sync-aligned way as the scanline counter.

Timing values are copied into shadow registers on reset and at the frame wrap. A mid-frame reprogram therefore takes effect only at the next frame. Legal settings are:

- 1 ≤ hblank start < htotal;
- 1 ≤ hsync start < htotal;
- 1 ≤ vblank start < vblank end ≤ vtotal.

Top module: `disp_timing_gen`

## Requirements
- R1: `hPos` counts 0..htotal-1 and then returns to 0. `lineIdx` advances when `hPos` wraps, and returns to 0 after line vtotal-1. (0,0) is the first active pixel of the first active line.
- R2: `scanLine` changes only in the cycle where `hPos` reaches hsync start. From hsync start of line v until hsync start of line v+1 it reads v. On line 0 before sync it therefore still reads the last line index of the previous frame, which is vtotal-1. The step from vtotal-1 to 0 happens at hsync start of line 0.
- R3: `vblankEvt` is high for exactly one cycle per frame. That cycle is the one where `hPos` equals hsync start on line vblank start - 1.
- R4: In the `vblankEvt` cycle, `pixelCount` equals htotal*(vblank start - 1) + hsync start.
- R5: `frameStartEvt` is high for exactly one cycle per frame. That cycle is the one where `hPos` equals hblank start on line vblank start.
- R6: `pixelCount` equals `lineIdx`*htotal + `hPos`. It is 0 at the first active pixel and returns to 0 after htotal*vtotal-1.
- R7: `inVblank` rises in the `vblankEvt` cycle. It falls in the cycle where `hPos` equals hsync start on line vblank end - 1.
- R8: While `rst` is high, the following state is loaded:
  - `hPos`, `lineIdx` and `pixelCount` go to 0;
  - `scanLine` goes to `cfgVtotal`-1;
  - both events and `inVblank` go low;
  - the configuration inputs are captured.
- R9: The configuration inputs are captured only on reset and at the frame wrap. A change made mid-frame has no effect on any output before the first pixel of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgHtotal | input | HW | Pixels per line |
| cfgHblankStart | input | HW | Pixel position where horizontal blanking begins |
| cfgHsyncStart | input | HW | Pixel position where horizontal sync begins |
| cfgVtotal | input | VW | Lines per frame |
| cfgVblankStart | input | VW | First blanked line |
| cfgVblankEnd | input | VW | Line after the last blanked line |
| hPos | output | HW | Horizontal position within the line |
| lineIdx | output | VW | True line index within the frame |
| scanLine | output | VW | Sync-aligned scanline counter |
| pixelCount | output | HW+VW | Frame pixel counter |
| vblankEvt | output | 1 | Start-of-vblank event strobe |
| frameStartEvt | output | 1 | Frame-start event strobe |
| inVblank | output | 1 | Sync-aligned vblank window flag |

## Verification
A cycle-level model of the raster is run against four timing sets. Each set is chosen to separate one kind of error:

- a typical geometry with sync after blanking start;
- a short frame whose vblank window ends before the last line;
- a minimal geometry where the vblank event falls on line 0 and sync sits at pixel 2;
- a geometry with sync on the last pixel of the line.

Between them, these sets separate an increment taken at line start from one taken at sync start. They also catch off-by-one errors on the event lines and wrap faults at each counter boundary.

A mid-frame reprogram between two different geometries shows whether the shadow capture waits for the frame wrap. The frame before the wrap must keep its old length, and the frame after it must take the new one.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

  // Control-to-datapath strobes, all decoded from the current raster position
  // so that the datapath registers land on the exact target pixel.
  typedef struct packed {
    logic lineEnd;       // hPos is on the last pixel of the line
    logic frameEnd;      // last pixel of the last line
    logic syncNext;      // next pixel is hsync start
    logic vbStartNext;   // next pixel is hsync start of line vblank_start-1
    logic vbEndNext;     // next pixel is hsync start of line vblank_end-1
    logic frmStartNext;  // next pixel is hblank start of line vblank_start
  } dtgStrobe_t;

endpackage

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] cfgHtotal,
  input  logic [HW-1:0] cfgHblankStart,
  input  logic [HW-1:0] cfgHsyncStart,
  input  logic [VW-1:0] cfgVtotal,
  input  logic [VW-1:0] cfgVblankStart,
  input  logic [VW-1:0] cfgVblankEnd,
  input  logic [HW-1:0] hPos,
  input  logic [VW-1:0] lineIdx,
  output dtgStrobe_t    strobe,
  output logic [HW-1:0] shHtotal,
  output logic [HW-1:0] shHblank,
  output logic [HW-1:0] shHsync,
  output logic [VW-1:0] shVtotal,
  output logic [VW-1:0] shVbStart,
  output logic [VW-1:0] shVbEnd
);

  localparam logic [HW-1:0] H_ONE = HW'(1);
  localparam logic [VW-1:0] V_ONE = VW'(1);

  logic lastPix;
  logic lastLine;
  logic preSync;
  logic preBlank;
  logic armed;

  // Position decode against the shadowed timing set
  always_comb begin
    lastPix  = (hPos == shHtotal - H_ONE);
    lastLine = (lineIdx == shVtotal - V_ONE);
    preSync  = (hPos == shHsync - H_ONE);
    preBlank = (hPos == shHblank - H_ONE);

    strobe.lineEnd      = lastPix;
    strobe.frameEnd     = lastPix && lastLine;
    strobe.syncNext     = preSync;
    strobe.vbStartNext  = preSync && (lineIdx == shVbStart - V_ONE);
    strobe.vbEndNext    = preSync && (lineIdx == shVbEnd - V_ONE);
    strobe.frmStartNext = preBlank && (lineIdx == shVbStart);
  end

  // Shadow capture: only at reset and at the frame wrap (R9)
  always_ff @(posedge clk) begin
    if (rst || strobe.frameEnd) begin
      shHtotal  <= cfgHtotal;
      shHblank  <= cfgHblankStart;
      shHsync   <= cfgHsyncStart;
      shVtotal  <= cfgVtotal;
      shVbStart <= cfgVblankStart;
      shVbEnd   <= cfgVblankEnd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R9: timing set only moves on the first pixel of a frame
  p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    !(hPos == '0 && lineIdx == '0) |->
      ($stable(shHtotal) && $stable(shHsync) && $stable(shHblank) &&
       $stable(shVtotal) && $stable(shVbStart) && $stable(shVbEnd)));

  // R1: raster coordinate stays inside the programmed frame
  p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
    (hPos < shHtotal) && (lineIdx < shVtotal));

endmodule

// File: rtl/dtg_dpath.sv
module dtg_dpath
  import dtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int PW = HW + VW
) (
  input  logic          clk,
  input  logic          rst,
  input  dtgStrobe_t    strobe,
  input  logic [VW-1:0] rstVtotal,
  input  logic [HW-1:0] shHtotal,
  input  logic [HW-1:0] shHblank,
  input  logic [HW-1:0] shHsync,
  input  logic [VW-1:0] shVbStart,
  output logic [HW-1:0] hPos,
  output logic [VW-1:0] lineIdx,
  output logic [VW-1:0] scanLine,
  output logic [PW-1:0] pixCnt,
  output logic          vbPulse,
  output logic          fsPulse,
  output logic          inVb
);

  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      hPos     <= '0;
      lineIdx  <= '0;
      pixCnt   <= '0;
      scanLine <= rstVtotal - VW'(1);
      vbPulse  <= 1'b0;
      fsPulse  <= 1'b0;
      inVb     <= 1'b0;
      armed    <= 1'b0;
    end else begin
      armed <= 1'b1;

      // Horizontal position and true line index
      hPos <= strobe.lineEnd ? '0 : hPos + HW'(1);
      if (strobe.lineEnd)
        lineIdx <= strobe.frameEnd ? '0 : lineIdx + VW'(1);

      // Frame pixel counter anchored at first active pixel
      pixCnt <= strobe.frameEnd ? '0 : pixCnt + PW'(1);

      // Scanline steps at hsync leading edge to the current true line
      if (strobe.syncNext)
        scanLine <= lineIdx;

      // Event strobes land on their target pixel
      vbPulse <= strobe.vbStartNext;
      fsPulse <= strobe.frmStartNext;

      // Sync-aligned vblank window
      if (strobe.vbStartNext)
        inVb <= 1'b1;
      else if (strobe.vbEndNext)
        inVb <= 1'b0;
    end
  end

  // R2: the scanline counter only moves at hsync start
  p_scan_step_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    (scanLine != $past(scanLine)) |-> (hPos == shHsync));

  // R3: vblank event sits at hsync start of the last active line
  p_vblank_pos_r3: assert property (@(posedge clk) disable iff (rst)
    vbPulse |-> (hPos == shHsync) && (lineIdx == shVbStart - VW'(1)));

  // R4: pixel counter value seen by the vblank event
  p_vblank_pix_r4: assert property (@(posedge clk) disable iff (rst)
    vbPulse |-> (pixCnt == PW'(shHtotal) * PW'(shVbStart - VW'(1)) + PW'(shHsync)));

  // R5: frame-start event sits at hblank start of the first blanked line
  p_frame_start_r5: assert property (@(posedge clk) disable iff (rst)
    fsPulse |-> (hPos == shHblank) && (lineIdx == shVbStart));

  // R6: pixel counter origin coincides with raster origin
  p_pix_origin_r6: assert property (@(posedge clk) disable iff (rst)
    (pixCnt == '0) == ((hPos == '0) && (lineIdx == '0)));

  // R7: vblank flag rises only together with the vblank event
  p_vblank_flag_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(inVb) |-> vbPulse);

  // R3: event strobes last a single cycle
  p_evt_single_r3: assert property (@(posedge clk) disable iff (rst)
    vbPulse |=> !vbPulse);

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12,
  localparam int PW = HW + VW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] cfgHtotal,
  input  logic [HW-1:0] cfgHblankStart,
  input  logic [HW-1:0] cfgHsyncStart,
  input  logic [VW-1:0] cfgVtotal,
  input  logic [VW-1:0] cfgVblankStart,
  input  logic [VW-1:0] cfgVblankEnd,
  output logic [HW-1:0] hPos,
  output logic [VW-1:0] lineIdx,
  output logic [VW-1:0] scanLine,
  output logic [PW-1:0] pixelCount,
  output logic          vblankEvt,
  output logic          frameStartEvt,
  output logic          inVblank
);

  dtgStrobe_t    strobe;
  logic [HW-1:0] shHtotal;
  logic [HW-1:0] shHblank;
  logic [HW-1:0] shHsync;
  logic [VW-1:0] shVtotal;
  logic [VW-1:0] shVbStart;
  logic [VW-1:0] shVbEnd;

  dtg_ctrl #(.HW(HW), .VW(VW)) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .cfgHtotal     (cfgHtotal),
    .cfgHblankStart(cfgHblankStart),
    .cfgHsyncStart (cfgHsyncStart),
    .cfgVtotal     (cfgVtotal),
    .cfgVblankStart(cfgVblankStart),
    .cfgVblankEnd  (cfgVblankEnd),
    .hPos          (hPos),
    .lineIdx       (lineIdx),
    .strobe        (strobe),
    .shHtotal      (shHtotal),
    .shHblank      (shHblank),
    .shHsync       (shHsync),
    .shVtotal      (shVtotal),
    .shVbStart     (shVbStart),
    .shVbEnd       (shVbEnd)
  );

  dtg_dpath #(.HW(HW), .VW(VW), .PW(PW)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .rstVtotal(cfgVtotal),
    .shHtotal (shHtotal),
    .shHblank (shHblank),
    .shHsync  (shHsync),
    .shVbStart(shVbStart),
    .hPos     (hPos),
    .lineIdx  (lineIdx),
    .scanLine (scanLine),
    .pixCnt   (pixelCount),
    .vbPulse  (vblankEvt),
    .fsPulse  (frameStartEvt),
    .inVb     (inVblank)
  );

endmodule

// File: tb/tb_disp_timing_gen.sv
module tb_disp_timing_gen;

  localparam int HW = 12;
  localparam int VW = 12;
  localparam int PW = HW + VW;
  localparam int NCFG = 4;
  // {htotal, hblank start, hsync start, vtotal, vblank start, vblank end}
  localparam int CFGS [NCFG][6] = '{
    '{10, 7, 8, 6, 4, 6},
    '{12, 9, 10, 5, 3, 4},
    '{ 7, 1, 2, 4, 1, 3},
    '{ 9, 5, 8, 8, 7, 8}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HW-1:0] cfgHtotal, cfgHblankStart, cfgHsyncStart;
  logic [VW-1:0] cfgVtotal, cfgVblankStart, cfgVblankEnd;
  logic [HW-1:0] hPos;
  logic [VW-1:0] lineIdx, scanLine;
  logic [PW-1:0] pixelCount;
  logic vblankEvt, frameStartEvt, inVblank;

  always #5 clk = ~clk;

  disp_timing_gen #(.HW(HW), .VW(VW)) dut (
    .clk(clk), .rst(rst),
    .cfgHtotal(cfgHtotal), .cfgHblankStart(cfgHblankStart),
    .cfgHsyncStart(cfgHsyncStart), .cfgVtotal(cfgVtotal),
    .cfgVblankStart(cfgVblankStart), .cfgVblankEnd(cfgVblankEnd),
    .hPos(hPos), .lineIdx(lineIdx), .scanLine(scanLine),
    .pixelCount(pixelCount), .vblankEvt(vblankEvt),
    .frameStartEvt(frameStartEvt), .inVblank(inVblank)
  );

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // Model state, derived from the requirements
  int mh, mv, ms, mi;
  int sht, shb, shs, svt, svbs, svbe;

  task automatic chk(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d line=%0d)", tag, act, exp, mh, mv);
    end
  endtask

  task automatic setCfg(int k);
    cfgHtotal      = HW'(CFGS[k][0]);
    cfgHblankStart = HW'(CFGS[k][1]);
    cfgHsyncStart  = HW'(CFGS[k][2]);
    cfgVtotal      = VW'(CFGS[k][3]);
    cfgVblankStart = VW'(CFGS[k][4]);
    cfgVblankEnd   = VW'(CFGS[k][5]);
  endtask

  task automatic loadShadow();
    sht = int'(cfgHtotal); shb = int'(cfgHblankStart); shs = int'(cfgHsyncStart);
    svt = int'(cfgVtotal); svbs = int'(cfgVblankStart); svbe = int'(cfgVblankEnd);
  endtask

  task automatic compareAll();
    int expVb;
    expVb = (mh == shs && mv == svbs - 1) ? 1 : 0;
    chk("R1 hPos", hPos, mh);
    chk("R1 lineIdx", lineIdx, mv);
    chk("R2 scanLine", scanLine, ms);
    chk("R6 pixelCount", pixelCount, mv * sht + mh);
    chk("R3 vblankEvt", vblankEvt, expVb);
    chk("R5 frameStartEvt", frameStartEvt, (mh == shb && mv == svbs) ? 1 : 0);
    chk("R7 inVblank", inVblank, mi);
    if (expVb == 1)
      chk("R4 pixelCount at vblank event", pixelCount, sht * (svbs - 1) + shs);
  endtask

  task automatic advance();
    mh++;
    if (mh == sht) begin
      mh = 0;
      mv++;
      if (mv == svt) begin
        mv = 0;
        loadShadow();
      end
    end
    if (mh == shs) begin
      ms = mv;
      if (mv == svbs - 1) mi = 1;
      else if (mv == svbe - 1) mi = 0;
    end
  endtask

  task automatic doReset(int k);
    @(negedge clk);
    setCfg(k);
    rst = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    loadShadow();
    mh = 0; mv = 0; ms = svt - 1; mi = 0;
    // R8: reset state
    chk("R8 reset hPos", hPos, 0);
    chk("R8 reset lineIdx", lineIdx, 0);
    chk("R8 reset scanLine", scanLine, svt - 1);
    chk("R8 reset pixelCount", pixelCount, 0);
    chk("R8 reset events", {vblankEvt, frameStartEvt, inVblank}, 0);
  endtask

  task automatic runCycles(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      advance();
      compareAll();
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    setCfg(0);
    // Table walk: each timing set, two full frames plus a few pixels
    for (int k = 0; k < NCFG; k++) begin
      doReset(k);
      runCycles(2 * CFGS[k][0] * CFGS[k][3] + 5);
    end

    // Directed R9: reprogram mid-frame, old geometry must hold until wrap
    doReset(0);
    runCycles(25);
    setCfg(1);
    runCycles(60 - 25 - 2);
    chk("R9 old geometry hPos before wrap", hPos, 8);
    chk("R9 old geometry line before wrap", lineIdx, 5);
    runCycles(1);
    chk("R9 old htotal kept hPos", hPos, 9);
    runCycles(1);
    chk("R9 wrap to origin", hPos, 0);
    runCycles(11);
    chk("R9 new htotal hPos", hPos, 11);
    runCycles(12 * 5 * 2);

    // Directed R2: line 0 of a frame, before and at hsync start
    doReset(0);
    runCycles(7);
    chk("R2 scanLine before sync on line 0", scanLine, 5);
    runCycles(1);
    chk("R2 scanLine wraps at sync of line 0", scanLine, 0);

    finished = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
      $finish;
    end
  end

endmodule